// File: doc/BRIEF.md
# Shortenable Successive-Approximation Register

This block holds the digital side of a successive-approximation converter. After a start, it sets the most significant trial bit and presents the code to an external DAC. On each following clock it resolves one bit from the comparator input, working from the top bit down. It then sets the next lower bit for trial. It raises an end flag when the last bit is resolved. Each decision also leaves the block one clock later as a serial stream.

A feed-forward input ends a conversion early. Tie one of the block's own code outputs back into it to get a shorter word. Any bits below the tap are left undecided and should be ignored.

The start decode has no stable idle state while the end flag is low. A start level that is held high makes the block begin a new conversion on the edge after each finish. This keeps free-running and cascaded loops from locking up.

Top module: `sar_ff_register`

## Requirements
- R1: While rst_ni is low, q_o, eoc_o and ser_o are all 0.
- R2: The first clock edge after reset begins a conversion whatever start_i is: q_o becomes the top bit alone (0x80 for 8 bits) and eoc_o stays 0.
- R3: With ff_i low, eoc_o rises on the eighth edge after the starting edge. q_o then holds the resolved code.
- R4: Bits are tried from the top bit down. On each edge the bit under trial keeps the value of cmp_i (1 keeps it, 0 clears it), and the next lower bit is set to 1.
- R5: In the period after the starting edge, ser_o is 0. In the period after the edge that resolves a bit, ser_o equals that bit's decision.
- R6: While eoc_o is 1 and start_i is low, q_o and eoc_o hold and ser_o is 0, whatever cmp_i and ff_i do.
- R7: While eoc_o is 1, start_i high on an edge starts a new conversion: eoc_o falls and q_o becomes the top bit alone.
- R8: While eoc_o is 0, start_i high on an edge after an edge where it was low restarts the conversion.
- R9: While eoc_o is 0, start_i high on two edges in a row does not restart. The conversion continues to its end.
- R10: ff_i high on an edge that resolves a bit makes that bit the last one: eoc_o rises on that edge. With q_o[1] fed into ff_i, eoc_o rises on the seventh edge and q_o[7:1] holds the decisions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; every input is sampled on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start level / start pulse |
| cmp_i | input | 1 | Comparator decision for the bit under trial |
| ff_i | input | 1 | Feed-forward: the current decision is the final one |
| q_o | output | WIDTH | Trial / result code, top bit first |
| eoc_o | output | 1 | End of conversion |
| ser_o | output | 1 | Serial decision stream |

## Verification
The bench models the comparator as "trial code not above the input value" and checks that the finished code equals that value. It also checks each serial bit as it appears, so a design that shifted the trial order, or put ser_o one period late, would mismatch. Start handling is probed at three points. A held start must recirculate from the end state, or the block would lock. A start held through a conversion must not restart it, or the block would never finish. A fresh rising start in the middle of a conversion must restart it. Feed-forward from q_o[1] must end the word a bit early, which catches a design that ignores ff_i or ends one edge late.

// File: rtl/sar_ff_pkg.sv
package sar_ff_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_START = 2'd1,
    ACT_STEP  = 2'd2
  } sar_act_e;
endpackage

// File: rtl/sar_start_ctl.sv
module sar_start_ctl
  import sar_ff_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  logic     eoc_i,
  input  logic     idle_i,
  output sar_act_e act_o
);
  logic start_prev_q;

  // previous start level reads as 0 after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_prev_q <= 1'b0;
    else         start_prev_q <= start_i;
  end

  always_comb begin
    if (!eoc_i && idle_i)                          act_o = ACT_START; // nothing under trial: no idle lock
    else if (start_i && (eoc_i || !start_prev_q))  act_o = ACT_START;
    else if (!eoc_i)                               act_o = ACT_STEP;
    else                                           act_o = ACT_HOLD;
  end
endmodule

// File: rtl/sar_trial_path.sv
module sar_trial_path
  import sar_ff_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  sar_act_e         act_i,
  input  logic             cmp_i,
  input  logic             ff_i,
  output logic [WIDTH-1:0] q_o,
  output logic             idle_o,
  output logic             last_o
);
  localparam logic [WIDTH-1:0] TopBit = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] mask_q;
  logic [WIDTH-1:0] q_q;

  assign idle_o = ~|mask_q;
  assign last_o = (act_i == ACT_STEP) && (mask_q[0] || ff_i);
  assign q_o    = q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else begin
      case (act_i)
        ACT_START: mask_q <= TopBit;
        ACT_STEP:  mask_q <= last_o ? '0 : (mask_q >> 1);
        default:   mask_q <= mask_q;
      endcase
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic set_next;
    if (i == WIDTH-1) begin : g_top
      assign set_next = 1'b0;
    end else begin : g_low
      assign set_next = mask_q[i+1] && !last_o;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_q[i] <= 1'b0;
      else if (act_i == ACT_START) q_q[i] <= (i == WIDTH-1);
      else if (act_i == ACT_STEP) begin
        if (mask_q[i])    q_q[i] <= cmp_i;
        else if (set_next) q_q[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sar_done_ser.sv
module sar_done_ser
  import sar_ff_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  sar_act_e act_i,
  input  logic     last_i,
  input  logic     cmp_i,
  output logic     eoc_o,
  output logic     ser_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eoc_o <= 1'b0;
      ser_o <= 1'b0;
    end else begin
      if (act_i == ACT_START) eoc_o <= 1'b0;
      else if (last_i)        eoc_o <= 1'b1;
      // inhibited low except in the period after a decision
      ser_o <= (act_i == ACT_STEP) ? cmp_i : 1'b0;
    end
  end
endmodule

// File: rtl/sar_ff_register.sv
module sar_ff_register
  import sar_ff_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmp_i,
  input  logic             ff_i,
  output logic [WIDTH-1:0] q_o,
  output logic             eoc_o,
  output logic             ser_o
);
  sar_act_e act;
  logic     idle;
  logic     last;

  sar_start_ctl u_start (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .eoc_i  (eoc_o),
    .idle_i (idle),
    .act_o  (act)
  );

  sar_trial_path #(.WIDTH(WIDTH)) u_trial (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .act_i (act),
    .cmp_i (cmp_i),
    .ff_i  (ff_i),
    .q_o   (q_o),
    .idle_o(idle),
    .last_o(last)
  );

  sar_done_ser u_done (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .act_i (act),
    .last_i(last),
    .cmp_i (cmp_i),
    .eoc_o (eoc_o),
    .ser_o (ser_o)
  );
endmodule

// File: rtl/sar_ff_register_chk.sv
module sar_ff_register_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             cmp_i,
  input logic             ff_i,
  input logic [WIDTH-1:0] q_o,
  input logic             eoc_o,
  input logic             ser_o
);
  localparam logic [WIDTH-1:0] TopBit = {1'b1, {(WIDTH-1){1'b0}}};

  p_reset_r1: assert property (@(posedge clk_i) !rst_ni |-> (q_o == '0 && !eoc_o && !ser_o));

  p_no_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!eoc_o && !start_i) |=> (eoc_o || q_o != $past(q_o)));

  p_retain_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoc_o && !start_i) |=> (eoc_o && $stable(q_o) && !ser_o));

  p_recirc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoc_o && start_i) |=> (!eoc_o && q_o == TopBit));

  p_start_inhibit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoc_o && start_i) |=> !ser_o);

  p_ff_ends_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!eoc_o && ff_i && !start_i && q_o != '0) |=> eoc_o);
endmodule

bind sar_ff_register sar_ff_register_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .cmp_i  (cmp_i),
  .ff_i   (ff_i),
  .q_o    (q_o),
  .eoc_o  (eoc_o),
  .ser_o  (ser_o)
);

// File: tb/sar_ff_register_test.sv
`timescale 1ns/1ps
module sar_ff_register_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic         ff_tap;
  logic [W-1:0] vin;
  logic         cmp;
  logic         ff;
  logic [W-1:0] q;
  logic         eoc;
  logic         ser;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  // comparator model: keep the trial bit when the trial code does not exceed the input
  assign cmp = (q <= vin);
  assign ff  = ff_tap ? q[1] : 1'b0;

  sar_ff_register #(.WIDTH(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmp_i(cmp), .ff_i(ff),
    .q_o(q), .eoc_o(eoc), .ser_o(ser)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // starting edge assumed just passed; resolves all bits and checks the stream
  task automatic run_full(input string req);
    for (int k = W-1; k >= 0; k--) begin
      chk(eoc == 1'b0, {req, " eoc low during conversion"}, eoc, 0);
      tick();
      chk(ser == vin[k], "R5 serial bit", ser, vin[k]);
    end
    chk(eoc == 1'b1, {req, " eoc after eighth edge (R3)"}, eoc, 1);
    chk(q == vin, {req, " result code (R3)"}, q, vin);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; ff_tap = 1'b0; vin = 8'hA5;
    repeat (3) tick();
    chk(q == '0 && !eoc && !ser, "R1 reset state", {q, eoc, ser}, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_first();
    tick();
    chk(q == 8'h80, "R2 first edge starts", q, 8'h80);
    chk(eoc == 1'b0, "R2 eoc low", eoc, 0);
    chk(ser == 1'b0, "R5 inhibit after start", ser, 0);
    tick();
    chk(q == 8'hC0, "R4 top bit kept, next set", q, 8'hC0);
    chk(ser == 1'b1, "R5 first decision", ser, 1);
    for (int k = W-2; k >= 0; k--) begin
      tick();
      chk(ser == vin[k], "R5 serial bit", ser, vin[k]);
    end
    chk(eoc == 1'b1 && q == vin, "R3 full conversion", q, vin);
  endtask

  task automatic t_retain();
    logic [W-1:0] held = q;
    vin = 8'h00;
    ff_tap = 1'b1;
    repeat (3) tick();
    chk(q == held, "R6 code held", q, held);
    chk(eoc == 1'b1, "R6 eoc held", eoc, 1);
    chk(ser == 1'b0, "R6 serial low", ser, 0);
    ff_tap = 1'b0;
  endtask

  task automatic t_recirc();
    vin = 8'h3C; start = 1'b1;
    tick();
    chk(q == 8'h80 && !eoc, "R7 restart from end", {q, eoc}, {8'h80, 1'b0});
    chk(ser == 1'b0, "R5 inhibit after restart", ser, 0);
    run_full("R9 held start");
    vin = 8'hC3;
    tick();
    chk(q == 8'h80 && !eoc, "R7 recirculation", {q, eoc}, {8'h80, 1'b0});
    run_full("R9 second pass");
    start = 1'b0;
  endtask

  task automatic t_retrig();
    vin = 8'h11; start = 1'b1;
    tick();
    start = 1'b0;
    repeat (3) tick();
    chk(q[7:5] == 3'b000 && q[4] == 1'b1, "R4 lower trials", q, 8'h10);
    vin = 8'h5A; start = 1'b1;
    tick();
    chk(q == 8'h80 && !eoc, "R8 mid-conversion restart", {q, eoc}, {8'h80, 1'b0});
    start = 1'b0;
    run_full("R8 after restart");
  endtask

  task automatic t_short();
    vin = 8'hB7; ff_tap = 1'b1; start = 1'b1;
    tick();
    start = 1'b0;
    for (int e = 1; e <= 6; e++) begin
      tick();
      chk(eoc == 1'b0, "R10 not yet ended", eoc, 0);
    end
    tick();
    chk(eoc == 1'b1, "R10 eoc on seventh edge", eoc, 1);
    chk(q[7:1] == vin[7:1], "R10 upper decisions", q[7:1], vin[7:1]);
    chk(ser == vin[1], "R10 final serial bit", ser, vin[1]);
    tick();
    chk(eoc == 1'b1 && ser == 1'b0, "R6 held after short word", {eoc, ser}, 2'b10);
    ff_tap = 1'b0;
  endtask

  initial begin
    t_reset();
    t_first();
    t_retain();
    t_recirc();
    t_retain();
    t_retrig();
    t_short();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule